// File: doc/BRIEF.md
# Coherence Request Classifier and Arbiter

This block sits at the entry of a shared-cache coherence controller. Three message queues arrive at its inputs: unblock notices, responses, and requests from the first-level caches. On every cycle the block picks one queue head and turns it into a controller event code for the line it addresses. It also returns a dequeue strobe to the queue that was consumed. The event does not follow from the message type alone. It also depends on four things: whether the requestor is in the line's sharer set, how many acks are still outstanding, whether the sender is a first-level cache or memory, and whether the victim line is dirty.

For requests, the block looks up a small set-associative tag array. A hit, or a miss to a set that still has a free way, is classified normally. A miss to a full set leaves the request in its queue and raises a replacement event for the least-recently-used way of that set instead. The controller installs, changes and invalidates lines through an update port. Both a consumed hit and a valid install make the touched way the most recently used. Classification is combinational on the queue heads. Only the tag array and the age counters are stored.

Top module: `coh_event_frontend`

## Requirements
- R1: Exactly one queue is consumed per cycle at most, with unblock over response over request priority; a valid unblock head is always consumed, and a valid response head is consumed whenever no unblock is valid.
- R2: Unblock type 0 gives event 16 (unblock) and type 1 gives event 17 (exclusive unblock), with the unblock address as event address.
- R3: A response with the first-level sender flag set and type 0 (data) gives event 12 when its dirty flag is set and event 13 when it is clear.
- R4: A first-level response of type 1 (ack) gives event 15 when pending count minus carried count is zero modulo 2^ACK_W, and event 14 otherwise.
- R5: A response with the first-level flag clear gives event 9 for type 2 (memory data), 10 for type 3 (memory ack) and 11 for type 4 (external invalidate).
- R6: Any other unblock type, any other response type for its sender class, and request types 5 to 7 raise msg_err with ev_valid low, and the message is still dequeued.
- R7: A consumed request of type 0, 1 or 2 gives event 1 (read), 2 (instruction read) or 3 (exclusive read), with the request address as event address.
- R8: A request of type 3 (upgrade) gives event 4 when the line is present and its sharer bit for req_src is set, and event 3 otherwise.
- R9: A request of type 4 (writeback) gives event 5 when the line is present and its sharer bit for req_src is set, and event 6 otherwise.
- R10: A request whose line is absent from a set with all ways valid is not dequeued. It gives event 7 when the victim is dirty and event 8 when it is clean, with the event address {victim tag, set}. The set is the low SET_W address bits.
- R11: The victim is the least-recently-used way. A consumed hit makes its way most recently used. A valid install through the update port does the same, and in a cycle with upd_en the hit does not age the set.
- R12: After reset no line is present, and every set's ages run from way 0 as most recent to way WAYS-1 as least recent.
- R13: With no queue valid, ev_valid, msg_err and all dequeue strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unb_valid | input | 1 | Unblock queue head valid |
| unb_type | input | 3 | Unblock message type |
| unb_addr | input | ADDR_W | Unblock line address |
| rsp_valid | input | 1 | Response queue head valid |
| rsp_type | input | 3 | Response message type |
| rsp_addr | input | ADDR_W | Response line address |
| rsp_from_l1 | input | 1 | Sender is a first-level cache (else memory) |
| rsp_dirty | input | 1 | Data response carries dirty data |
| rsp_ack_cnt | input | ACK_W | Ack count carried by the response |
| rsp_pend_acks | input | ACK_W | Acks still pending for the line |
| req_valid | input | 1 | Request queue head valid |
| req_type | input | 3 | Request message type |
| req_addr | input | ADDR_W | Request line address |
| req_src | input | log2(NODES) | Requesting first-level cache index |
| upd_en | input | 1 | Write one tag entry |
| upd_addr | input | ADDR_W | Line address of the written entry |
| upd_way | input | log2(WAYS) | Way written |
| upd_valid | input | 1 | New valid bit |
| upd_dirty | input | 1 | New dirty bit |
| upd_sharers | input | NODES | New sharer set |
| ev_valid | output | 1 | Event code is meaningful |
| ev_code | output | 5 | Controller event |
| ev_addr | output | ADDR_W | Target line address of the event |
| deq_unb | output | 1 | Unblock head consumed |
| deq_rsp | output | 1 | Response head consumed |
| deq_req | output | 1 | Request head consumed |
| msg_err | output | 1 | Unrecognised message type |

## Verification
The bench builds the block with its defaults: 12-bit line addresses, four sets of four ways, four first-level caches and a 4-bit ack count. Request and update addresses use only six tags per set, so sets fill within a few dozen cycles. Hits, free-way misses and evictions then all occur often, and the age order is exercised through long chains of installs and hits. Ack counts are drawn from a small range, so the final-ack comparison is true often. Queue-valid mixes are chosen so that all priority combinations occur.

// File: rtl/coh_fe_pkg.sv
// Shared encodings for the coherence front end: event codes and message types.
package coh_fe_pkg;
    localparam int MSG_W = 3;
    localparam int EV_W  = 5;

    typedef enum logic [EV_W-1:0] {
        EV_NONE         = 5'd0,
        EV_READ         = 5'd1,
        EV_IREAD        = 5'd2,
        EV_XREAD        = 5'd3,
        EV_UPGRADE      = 5'd4,
        EV_WBACK        = 5'd5,
        EV_WBACK_STALE  = 5'd6,
        EV_REPL_DIRTY   = 5'd7,
        EV_REPL_CLEAN   = 5'd8,
        EV_MEM_DATA     = 5'd9,
        EV_MEM_ACK      = 5'd10,
        EV_EXT_INV      = 5'd11,
        EV_DATA_DIRTY   = 5'd12,
        EV_DATA_CLEAN   = 5'd13,
        EV_ACK          = 5'd14,
        EV_ACK_LAST     = 5'd15,
        EV_UNBLOCK      = 5'd16,
        EV_UNBLOCK_EXCL = 5'd17
    } coh_event_e;

    // request queue types
    localparam logic [MSG_W-1:0] RQ_READ  = 3'd0;
    localparam logic [MSG_W-1:0] RQ_IREAD = 3'd1;
    localparam logic [MSG_W-1:0] RQ_XREAD = 3'd2;
    localparam logic [MSG_W-1:0] RQ_UPGR  = 3'd3;
    localparam logic [MSG_W-1:0] RQ_WBACK = 3'd4;
    // response queue types
    localparam logic [MSG_W-1:0] RS_DATA     = 3'd0;
    localparam logic [MSG_W-1:0] RS_ACK      = 3'd1;
    localparam logic [MSG_W-1:0] RS_MEM_DATA = 3'd2;
    localparam logic [MSG_W-1:0] RS_MEM_ACK  = 3'd3;
    localparam logic [MSG_W-1:0] RS_MEM_INV  = 3'd4;
    // unblock queue types
    localparam logic [MSG_W-1:0] UB_PLAIN = 3'd0;
    localparam logic [MSG_W-1:0] UB_EXCL  = 3'd1;
endpackage

// File: rtl/coh_tag_store.sv
// Tag, valid, dirty and sharer storage for a set-associative array.
// Assumes one write per cycle through the update port; the lookup is
// combinational and sees the contents before that cycle's write.
module coh_tag_store #(
    parameter int SET_W = 2,
    parameter int TAG_W = 10,
    parameter int WAYS  = 4,
    parameter int NODES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SET_W-1:0]         wr_set,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic                     wr_valid,
    input  logic                     wr_dirty,
    input  logic [NODES-1:0]         wr_sharers,
    input  logic [SET_W-1:0]         rd_set,
    input  logic [TAG_W-1:0]         rd_tag,
    input  logic [$clog2(WAYS)-1:0]  vic_way,
    output logic                     hit,
    output logic [$clog2(WAYS)-1:0]  hit_way,
    output logic [NODES-1:0]         hit_sharers,
    output logic                     has_free,
    output logic [TAG_W-1:0]         vic_tag,
    output logic                     vic_dirty
);
    localparam int SETS  = 1 << SET_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [NODES-1:0] share_q [SETS][WAYS];
    logic             valid_q [SETS][WAYS];
    logic             dirty_q [SETS][WAYS];
    logic [WAYS-1:0]  way_match;
    logic [WAYS-1:0]  way_free;

    // Clear every entry on reset; otherwise write one entry when asked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= '0;
                    share_q[s][w] <= '0;
                end
            end
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= wr_valid;
            dirty_q[wr_set][wr_way] <= wr_dirty;
            tag_q[wr_set][wr_way]   <= wr_tag;
            share_q[wr_set][wr_way] <= wr_sharers;
        end
    end

    // Per-way tag compare and free detection for the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = valid_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
        assign way_free[w]  = !valid_q[rd_set][w];
    end

    // Encode the lowest matching way.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit         = |way_match;
    assign has_free    = |way_free;
    assign hit_sharers = share_q[rd_set][hit_way];
    assign vic_tag     = tag_q[rd_set][vic_way];
    assign vic_dirty   = dirty_q[rd_set][vic_way];
endmodule

// File: rtl/coh_lru_ages.sv
// Per-set age counters giving a true least-recently-used order.
// Assumes WAYS is a power of two; ages in a set always form a permutation
// of 0..WAYS-1, 0 most recent. The oldest way is the victim.
module coh_lru_ages #(
    parameter int SET_W = 2,
    parameter int WAYS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     touch_en,
    input  logic [SET_W-1:0]         touch_set,
    input  logic [$clog2(WAYS)-1:0]  touch_way,
    input  logic [SET_W-1:0]         look_set,
    output logic [$clog2(WAYS)-1:0]  vic_way
);
    localparam int SETS  = 1 << SET_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
    logic [WAYS-1:0]            oldest;

    // Reset ages to the way index; on a touch age the younger ways by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    // Flag the way holding the largest age in the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_old
        assign oldest[w] = (age_q[look_set][w] == '1);
    end

    // Encode the oldest way.
    always_comb begin
        vic_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (oldest[w]) vic_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/coh_event_classify.sv
// Combinational arbiter and classifier. Picks unblock over response over
// request, then maps the head message plus lookup results to an event.
// Assumes the lookup inputs describe the request head's set and tag.
module coh_event_classify
    import coh_fe_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SET_W  = 2,
    parameter int NODES  = 4,
    parameter int ACK_W  = 4
) (
    input  logic                      unb_valid,
    input  logic [MSG_W-1:0]          unb_type,
    input  logic [ADDR_W-1:0]         unb_addr,
    input  logic                      rsp_valid,
    input  logic [MSG_W-1:0]          rsp_type,
    input  logic [ADDR_W-1:0]         rsp_addr,
    input  logic                      rsp_from_l1,
    input  logic                      rsp_dirty,
    input  logic [ACK_W-1:0]          rsp_ack_cnt,
    input  logic [ACK_W-1:0]          rsp_pend_acks,
    input  logic                      req_valid,
    input  logic [MSG_W-1:0]          req_type,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [$clog2(NODES)-1:0]  req_src,
    input  logic                      hit,
    input  logic [NODES-1:0]          hit_sharers,
    input  logic                      has_free,
    input  logic [ADDR_W-SET_W-1:0]   vic_tag,
    input  logic                      vic_dirty,
    output logic                      ev_valid,
    output logic [EV_W-1:0]           ev_code,
    output logic [ADDR_W-1:0]         ev_addr,
    output logic                      deq_unb,
    output logic                      deq_rsp,
    output logic                      deq_req,
    output logic                      msg_err,
    output logic                      touch_en
);
    logic [ACK_W-1:0] acks_left;
    logic             is_sharer;

    assign acks_left = rsp_pend_acks - rsp_ack_cnt;
    assign is_sharer = hit && hit_sharers[req_src];

    // Select the head by priority and derive its event.
    always_comb begin
        ev_valid = 1'b0;
        ev_code  = EV_NONE;
        ev_addr  = '0;
        deq_unb  = 1'b0;
        deq_rsp  = 1'b0;
        deq_req  = 1'b0;
        msg_err  = 1'b0;
        touch_en = 1'b0;
        if (unb_valid) begin
            deq_unb = 1'b1;
            ev_addr = unb_addr;
            case (unb_type)
                UB_PLAIN: begin ev_valid = 1'b1; ev_code = EV_UNBLOCK;      end
                UB_EXCL:  begin ev_valid = 1'b1; ev_code = EV_UNBLOCK_EXCL; end
                default:  msg_err = 1'b1;
            endcase
        end else if (rsp_valid) begin
            deq_rsp = 1'b1;
            ev_addr = rsp_addr;
            if (rsp_from_l1) begin
                case (rsp_type)
                    RS_DATA: begin
                        ev_valid = 1'b1;
                        ev_code  = rsp_dirty ? EV_DATA_DIRTY : EV_DATA_CLEAN;
                    end
                    RS_ACK: begin
                        ev_valid = 1'b1;
                        ev_code  = (acks_left == '0) ? EV_ACK_LAST : EV_ACK;
                    end
                    default: msg_err = 1'b1;
                endcase
            end else begin
                case (rsp_type)
                    RS_MEM_DATA: begin ev_valid = 1'b1; ev_code = EV_MEM_DATA; end
                    RS_MEM_ACK:  begin ev_valid = 1'b1; ev_code = EV_MEM_ACK;  end
                    RS_MEM_INV:  begin ev_valid = 1'b1; ev_code = EV_EXT_INV;  end
                    default:     msg_err = 1'b1;
                endcase
            end
        end else if (req_valid) begin
            ev_addr = req_addr;
            if (req_type > RQ_WBACK) begin
                msg_err = 1'b1;
                deq_req = 1'b1;
            end else if (hit || has_free) begin
                deq_req  = 1'b1;
                ev_valid = 1'b1;
                touch_en = hit;
                case (req_type)
                    RQ_READ:  ev_code = EV_READ;
                    RQ_IREAD: ev_code = EV_IREAD;
                    RQ_XREAD: ev_code = EV_XREAD;
                    RQ_UPGR:  ev_code = is_sharer ? EV_UPGRADE : EV_XREAD;
                    default:  ev_code = is_sharer ? EV_WBACK : EV_WBACK_STALE;
                endcase
            end else begin
                ev_valid = 1'b1;
                ev_code  = vic_dirty ? EV_REPL_DIRTY : EV_REPL_CLEAN;
                ev_addr  = {vic_tag, req_addr[SET_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/coh_event_frontend.sv
// Front end of a shared-cache coherence controller: arbitrates three
// message queues, looks up the tag array for requests and emits one
// event with a dequeue strobe per cycle. Assumes WAYS is a power of two
// and that the controller keeps the tag array current through upd_*.
module coh_event_frontend
    import coh_fe_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SET_W  = 2,
    parameter int WAYS   = 4,
    parameter int NODES  = 4,
    parameter int ACK_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      unb_valid,
    input  logic [2:0]                unb_type,
    input  logic [ADDR_W-1:0]         unb_addr,
    input  logic                      rsp_valid,
    input  logic [2:0]                rsp_type,
    input  logic [ADDR_W-1:0]         rsp_addr,
    input  logic                      rsp_from_l1,
    input  logic                      rsp_dirty,
    input  logic [ACK_W-1:0]          rsp_ack_cnt,
    input  logic [ACK_W-1:0]          rsp_pend_acks,
    input  logic                      req_valid,
    input  logic [2:0]                req_type,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [$clog2(NODES)-1:0]  req_src,
    input  logic                      upd_en,
    input  logic [ADDR_W-1:0]         upd_addr,
    input  logic [$clog2(WAYS)-1:0]   upd_way,
    input  logic                      upd_valid,
    input  logic                      upd_dirty,
    input  logic [NODES-1:0]          upd_sharers,
    output logic                      ev_valid,
    output logic [4:0]                ev_code,
    output logic [ADDR_W-1:0]         ev_addr,
    output logic                      deq_unb,
    output logic                      deq_rsp,
    output logic                      deq_req,
    output logic                      msg_err
);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] vic_way;
    logic [NODES-1:0] hit_sharers;
    logic             has_free;
    logic [TAG_W-1:0] vic_tag;
    logic             vic_dirty;
    logic             hit_touch;
    logic             touch_en;
    logic [SET_W-1:0] touch_set;
    logic [WAY_W-1:0] touch_way;

    coh_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W), .WAYS(WAYS), .NODES(NODES)) i_tags (
        .clk(clk), .rst_n(rst_n),
        .wr_en(upd_en), .wr_set(upd_addr[SET_W-1:0]), .wr_way(upd_way),
        .wr_tag(upd_addr[ADDR_W-1:SET_W]), .wr_valid(upd_valid),
        .wr_dirty(upd_dirty), .wr_sharers(upd_sharers),
        .rd_set(req_addr[SET_W-1:0]), .rd_tag(req_addr[ADDR_W-1:SET_W]),
        .vic_way(vic_way), .hit(hit), .hit_way(hit_way),
        .hit_sharers(hit_sharers), .has_free(has_free),
        .vic_tag(vic_tag), .vic_dirty(vic_dirty)
    );

    // An install through the update port takes the age update over a hit.
    always_comb begin
        if (upd_en) begin
            touch_en  = upd_valid;
            touch_set = upd_addr[SET_W-1:0];
            touch_way = upd_way;
        end else begin
            touch_en  = hit_touch;
            touch_set = req_addr[SET_W-1:0];
            touch_way = hit_way;
        end
    end

    coh_lru_ages #(.SET_W(SET_W), .WAYS(WAYS)) i_ages (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
        .look_set(req_addr[SET_W-1:0]), .vic_way(vic_way)
    );

    coh_event_classify #(.ADDR_W(ADDR_W), .SET_W(SET_W), .NODES(NODES), .ACK_W(ACK_W)) i_cls (
        .unb_valid(unb_valid), .unb_type(unb_type), .unb_addr(unb_addr),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_addr(rsp_addr),
        .rsp_from_l1(rsp_from_l1), .rsp_dirty(rsp_dirty),
        .rsp_ack_cnt(rsp_ack_cnt), .rsp_pend_acks(rsp_pend_acks),
        .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
        .req_src(req_src), .hit(hit), .hit_sharers(hit_sharers),
        .has_free(has_free), .vic_tag(vic_tag), .vic_dirty(vic_dirty),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_addr(ev_addr),
        .deq_unb(deq_unb), .deq_rsp(deq_rsp), .deq_req(deq_req),
        .msg_err(msg_err), .touch_en(hit_touch)
    );
endmodule

// File: rtl/coh_event_frontend_chk.sv
// Port-level properties of the coherence front end, bound to the top.
module coh_event_frontend_chk
    import coh_fe_pkg::*;
#(
    parameter int ACK_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unb_valid,
    input logic             rsp_valid,
    input logic [2:0]       rsp_type,
    input logic             rsp_from_l1,
    input logic [ACK_W-1:0] rsp_ack_cnt,
    input logic [ACK_W-1:0] rsp_pend_acks,
    input logic             req_valid,
    input logic             ev_valid,
    input logic [4:0]       ev_code,
    input logic             deq_unb,
    input logic             deq_rsp,
    input logic             deq_req,
    input logic             msg_err
);
    assert_one_dequeue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({deq_unb, deq_rsp, deq_req}));

    assert_unblock_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        unb_valid |-> deq_unb);

    assert_response_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!unb_valid && rsp_valid) |-> deq_rsp);

    assert_final_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_rsp && rsp_from_l1 && rsp_type == RS_ACK && rsp_pend_acks == rsp_ack_cnt)
            |-> (ev_valid && ev_code == EV_ACK_LAST));

    assert_error_no_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_err |-> !ev_valid);

    assert_replace_keeps_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_code == EV_REPL_DIRTY || ev_code == EV_REPL_CLEAN))
            |-> (req_valid && !deq_req));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!unb_valid && !rsp_valid && !req_valid)
            |-> (!ev_valid && !msg_err && !deq_unb && !deq_rsp && !deq_req));
endmodule

bind coh_event_frontend coh_event_frontend_chk #(.ACK_W(ACK_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .unb_valid(unb_valid), .rsp_valid(rsp_valid),
    .rsp_type(rsp_type), .rsp_from_l1(rsp_from_l1), .rsp_ack_cnt(rsp_ack_cnt),
    .rsp_pend_acks(rsp_pend_acks), .req_valid(req_valid), .ev_valid(ev_valid),
    .ev_code(ev_code), .deq_unb(deq_unb), .deq_rsp(deq_rsp), .deq_req(deq_req),
    .msg_err(msg_err)
);

// File: tb/test_coh_event_frontend.sv
// Behavioural reference model of the front end, compared on every clock.
module test_coh_event_frontend;
    localparam int ADDR_W = 12;
    localparam int NSETS  = 4;
    localparam int NWAYS  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unb_valid, rsp_valid, req_valid, upd_en;
    logic [2:0]  unb_type, rsp_type, req_type;
    logic [ADDR_W-1:0] unb_addr, rsp_addr, req_addr, upd_addr;
    logic        rsp_from_l1, rsp_dirty, upd_valid, upd_dirty;
    logic [3:0]  rsp_ack_cnt, rsp_pend_acks, upd_sharers;
    logic [1:0]  req_src, upd_way;
    logic        ev_valid, deq_unb, deq_rsp, deq_req, msg_err;
    logic [4:0]  ev_code;
    logic [ADDR_W-1:0] ev_addr;

    coh_event_frontend i_coh_event_frontend (
        .clk(clk), .rst_n(rst_n),
        .unb_valid(unb_valid), .unb_type(unb_type), .unb_addr(unb_addr),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_addr(rsp_addr),
        .rsp_from_l1(rsp_from_l1), .rsp_dirty(rsp_dirty),
        .rsp_ack_cnt(rsp_ack_cnt), .rsp_pend_acks(rsp_pend_acks),
        .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
        .req_src(req_src), .upd_en(upd_en), .upd_addr(upd_addr),
        .upd_way(upd_way), .upd_valid(upd_valid), .upd_dirty(upd_dirty),
        .upd_sharers(upd_sharers), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_addr(ev_addr), .deq_unb(deq_unb), .deq_rsp(deq_rsp),
        .deq_req(deq_req), .msg_err(msg_err)
    );

    always #10 clk = ~clk;   // 50 MHz

    // reference model state
    int        mtag  [NSETS][NWAYS];
    bit        mval  [NSETS][NWAYS];
    bit        mdirty[NSETS][NWAYS];
    bit [3:0]  msh   [NSETS][NWAYS];
    int        mage  [NSETS][NWAYS];
    int        vectors = 0;
    int        miscompares = 0;
    bit        done = 1'b0;
    string     tag_override = "";

    // expected outputs
    bit        e_v, e_du, e_dr, e_dq, e_err, e_tch;
    logic [4:0] e_code;
    logic [ADDR_W-1:0] e_addr;
    int        e_tset, e_tway;
    string     e_req;

    task automatic model_reset();
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NWAYS; w++) begin
                mval[s][w] = 0; mdirty[s][w] = 0; mtag[s][w] = 0; msh[s][w] = 0;
                mage[s][w] = w;
            end
    endtask

    task automatic touch(int s, int w);
        int a = mage[s][w];
        for (int i = 0; i < NWAYS; i++)
            if (mage[s][i] < a) mage[s][i]++;
        mage[s][w] = 0;
    endtask

    task automatic predict();
        int s, t, h, vw, nv;
        bit fr, sh;
        e_v = 0; e_du = 0; e_dr = 0; e_dq = 0; e_err = 0; e_tch = 0;
        e_code = 0; e_addr = 0; e_req = "R13";
        if (unb_valid) begin
            e_du = 1; e_addr = unb_addr; e_req = "R2";
            if (unb_type == 0) begin e_v = 1; e_code = 16; end
            else if (unb_type == 1) begin e_v = 1; e_code = 17; end
            else begin e_err = 1; e_req = "R6"; end
        end else if (rsp_valid) begin
            e_dr = 1; e_addr = rsp_addr;
            if (rsp_from_l1) begin
                if (rsp_type == 0) begin e_v = 1; e_code = rsp_dirty ? 12 : 13; e_req = "R3"; end
                else if (rsp_type == 1) begin
                    e_v = 1; e_req = "R4";
                    e_code = (((int'(rsp_pend_acks) - int'(rsp_ack_cnt)) & 15) == 0) ? 15 : 14;
                end else begin e_err = 1; e_req = "R6"; end
            end else begin
                e_req = "R5";
                if (rsp_type == 2) begin e_v = 1; e_code = 9; end
                else if (rsp_type == 3) begin e_v = 1; e_code = 10; end
                else if (rsp_type == 4) begin e_v = 1; e_code = 11; end
                else begin e_err = 1; e_req = "R6"; end
            end
        end else if (req_valid) begin
            s = int'(req_addr) % NSETS; t = int'(req_addr) / NSETS;
            h = -1; fr = 0;
            for (int w = 0; w < NWAYS; w++) begin
                if (mval[s][w] && mtag[s][w] == t && h < 0) h = w;
                if (!mval[s][w]) fr = 1;
            end
            e_addr = req_addr;
            if (req_type > 4) begin
                e_err = 1; e_dq = 1; e_req = "R6";
            end else if (h >= 0 || fr) begin
                e_dq = 1; e_v = 1;
                sh = (h >= 0) && msh[s][h][req_src];
                case (req_type)
                    0: begin e_code = 1; e_req = "R7"; end
                    1: begin e_code = 2; e_req = "R7"; end
                    2: begin e_code = 3; e_req = "R7"; end
                    3: begin e_code = sh ? 4 : 3; e_req = "R8"; end
                    default: begin e_code = sh ? 5 : 6; e_req = "R9"; end
                endcase
                if (h >= 0 && !upd_en) begin
                    e_tch = 1; e_tset = s; e_tway = h;
                    e_req = {e_req, " R11"};
                end
            end else begin
                vw = 0;
                for (int w = 0; w < NWAYS; w++) if (mage[s][w] == NWAYS - 1) vw = w;
                e_v = 1;
                e_code = mdirty[s][vw] ? 7 : 8;
                e_addr = ADDR_W'(mtag[s][vw] * NSETS + s);
                e_req = "R10 R11";
            end
        end
        nv = int'(unb_valid) + int'(rsp_valid) + int'(req_valid);
        if (nv > 1) e_req = {"R1 ", e_req};
        if (tag_override != "") e_req = tag_override;
    endtask

    task automatic commit();
        int s;
        if (upd_en) begin
            s = int'(upd_addr) % NSETS;
            mval[s][upd_way] = upd_valid;
            mdirty[s][upd_way] = upd_dirty;
            mtag[s][upd_way] = int'(upd_addr) / NSETS;
            msh[s][upd_way] = upd_sharers;
            if (upd_valid) touch(s, int'(upd_way));
        end else if (e_tch) begin
            touch(e_tset, e_tway);
        end
    endtask

    // Compare outputs with the model mid-cycle, update the model, advance.
    task automatic step();
        bit bad;
        #1;
        predict();
        vectors++;
        bad = (ev_valid !== e_v) || (msg_err !== e_err) || (deq_unb !== e_du) ||
              (deq_rsp !== e_dr) || (deq_req !== e_dq) ||
              (e_v && ((ev_code !== e_code) || (ev_addr !== e_addr)));
        if (bad) begin
            miscompares++;
            $display("FAIL %s: got v=%0b code=%0d addr=%0h deq=%b%b%b err=%b, expected v=%0b code=%0d addr=%0h deq=%b%b%b err=%b",
                     e_req, ev_valid, ev_code, ev_addr, deq_unb, deq_rsp, deq_req, msg_err,
                     e_v, e_code, e_addr, e_du, e_dr, e_dq, e_err);
        end
        commit();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        unb_valid = 0; rsp_valid = 0; req_valid = 0; upd_en = 0;
        unb_type = 0; rsp_type = 0; req_type = 0;
        unb_addr = 0; rsp_addr = 0; req_addr = 0; upd_addr = 0;
        rsp_from_l1 = 0; rsp_dirty = 0; rsp_ack_cnt = 0; rsp_pend_acks = 0;
        req_src = 0; upd_way = 0; upd_valid = 0; upd_dirty = 0; upd_sharers = 0;
    endtask

    task automatic do_req(int ty, int tg, int st, int src);
        idle_inputs();
        req_valid = 1; req_type = 3'(ty); req_addr = ADDR_W'(tg * NSETS + st); req_src = 2'(src);
        step();
    endtask

    task automatic do_fill(int tg, int st, int way, bit dirty, bit [3:0] sh);
        idle_inputs();
        upd_en = 1; upd_addr = ADDR_W'(tg * NSETS + st); upd_way = 2'(way);
        upd_valid = 1; upd_dirty = dirty; upd_sharers = sh;
        step();
    endtask

    initial begin
        idle_inputs();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 / R13: quiet after reset, and no line present
        tag_override = "R12 R13";
        step();
        tag_override = "R12";
        do_req(3, 1, 1, 1);              // upgrade to absent line -> exclusive read
        tag_override = "";
        // fill set 1 with tags 2..5; way 0 dirty, sharer node 1
        do_fill(2, 1, 0, 1, 4'b0010);
        do_fill(3, 1, 1, 0, 4'b0001);
        do_fill(4, 1, 2, 0, 4'b0001);
        do_fill(5, 1, 3, 0, 4'b0001);
        do_req(0, 9, 1, 0);              // R10: full set, dirty victim way 0
        do_req(0, 2, 1, 0);              // R11: hit refreshes way 0
        do_req(0, 9, 1, 0);              // R10: clean victim now way 1
        do_req(3, 2, 1, 1);              // R8: sharer upgrade
        do_req(3, 2, 1, 0);              // R8: non-sharer -> exclusive read
        do_req(4, 2, 1, 1);              // R9: writeback from sharer
        do_req(4, 2, 1, 2);              // R9: stale writeback
        do_req(6, 2, 1, 2);              // R6: bad request type
        // R1: all queues valid, unblock wins
        idle_inputs();
        unb_valid = 1; unb_type = 1; unb_addr = 12'h0a5;
        rsp_valid = 1; rsp_type = 2; req_valid = 1; req_addr = 12'h009;
        step();
        // R4: ack counting with wrap
        idle_inputs();
        rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 1; rsp_pend_acks = 3; rsp_ack_cnt = 3;
        step();
        idle_inputs();
        rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 1; rsp_pend_acks = 2; rsp_ack_cnt = 3;
        step();
        // random mix
        for (int n = 0; n < 5000; n++) begin
            unb_valid   = ($urandom % 100) < 15;
            unb_type    = 3'($urandom % 4);
            unb_addr    = ADDR_W'($urandom);
            rsp_valid   = ($urandom % 100) < 30;
            rsp_type    = 3'($urandom % 6);
            rsp_addr    = ADDR_W'($urandom);
            rsp_from_l1 = 1'($urandom % 2);
            rsp_dirty   = 1'($urandom % 2);
            rsp_ack_cnt = 4'($urandom % 4);
            rsp_pend_acks = 4'($urandom % 4);
            req_valid   = ($urandom % 100) < 75;
            req_type    = 3'($urandom % 6);
            req_addr    = ADDR_W'(($urandom % 6) * NSETS + ($urandom % NSETS));
            req_src     = 2'($urandom % 4);
            upd_en      = ($urandom % 100) < 25;
            upd_addr    = ADDR_W'(($urandom % 6) * NSETS + ($urandom % NSETS));
            upd_way     = 2'($urandom % 4);
            upd_valid   = ($urandom % 100) < 85;
            upd_dirty   = 1'($urandom % 2);
            upd_sharers = 4'($urandom % 16);
            step();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got no end of run, expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule